// File: doc/BRIEF.md
# SPI Command Response Checker

After a host sends a command frame to a peripheral over SPI, the peripheral returns a run of bytes. This block reads that run and decides whether the command succeeded. A single-cycle `start` pulse loads the opcode that was issued and whether CRC trailers are in use. The received bytes then arrive one per cycle on a valid-qualified byte interface. A `rx_last` marker flags the final byte the host clocked in.

For every command, the block expects the peripheral to echo the opcode and then send a zero status byte. Control commands (reset, terminate, repeat) have one extra leading byte, which the block drops. For read commands, the block then looks for a data-start header. For register reads it also collects four data bytes into a word and consumes the CRC trailer when CRC is enabled. The outcome is a one-cycle `done` pulse with a two-bit result (ok, fail or reset-required) and an overrun flag. These outputs hold until the next command.

Top module: `spi_rsp_check`

## Requirements
- R1: For control opcodes 0xCF, 0xC5 and 0xC6, the first received byte is discarded whatever its value, and the echo is taken from the second byte.
- R2: If the echo byte differs from the loaded opcode, `done` rises in the cycle after that byte with result 2'b01 (fail). Result encoding: 2'b00 ok, 2'b01 fail, 2'b10 reset-required.
- R3: A status byte (the byte after the echo) other than 0x00 ends the command with result fail.
- R4: For write opcodes 0xC1, 0xC3, 0xC7, 0xC9 and for control opcodes, a matching echo followed by status 0x00 gives ok in the cycle after the status byte. `done` stays low on every earlier byte.
- R5: For read opcodes 0xCA, 0xC4, 0xC2 and 0xC8, the bytes after the status byte are scanned for a header whose upper nibble is 0xF. Result reset-required is given if 100 bytes pass without a header, or if the stream ends before a header. A header on the 100th scanned byte is still accepted.
- R6: For 0xCA and 0xC4, the 4 bytes after the header are packed into `rd_word`, with the first byte in bits 7:0. With CRC off, ok follows the 4th byte. With CRC on, two more bytes are consumed and ok follows the second of them.
- R7: For 0xC2 and 0xC8, ok is given in the cycle after the header byte.
- R8: If `rx_last` marks a byte after which a dropped, echo, status, data or CRC byte is still required, the result is fail with `overrun` = 1. `overrun` is 0 for every other outcome.
- R9: Any other opcode gives `done` with result fail in the cycle after `start`, without consuming any byte.
- R10: After reset, `done`, `overrun` and `rd_word` are 0 and `result` is 2'b00. Bytes received while no command is pending produce no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin checking a new command; loads opcode and crc_en |
| opcode | input | 8 | Opcode of the issued command |
| crc_en | input | 1 | A two-byte CRC trailer follows read data |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | This byte is the last of the received stream |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| result | output | 2 | 00 ok, 01 fail, 10 reset-required |
| overrun | output | 1 | Stream ended before required bytes arrived |
| rd_word | output | 32 | Register read data, first byte least significant |

## Verification
The hardest case to reach is the edge of the header search window. The verdict must switch between accepting a header and giving up on exactly the 100th scanned byte. To reach it, the stimulus feeds 99 filler bytes and then a header in one test, and 100 fillers in another. Both fillers have upper nibbles other than 0xF, so no filler can match by accident. The overrun paths are reached by setting `rx_last` on a byte in the middle of the echo, data or CRC phase. Each overrun run is followed by a clean command, to show that the flag clears.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;

    typedef enum logic [1:0] {
        RES_OK    = 2'b00,
        RES_FAIL  = 2'b01,
        RES_RESET = 2'b10
    } res_e;

    typedef enum logic [2:0] {
        CLS_BAD,
        CLS_CTRL,
        CLS_WRITE,
        CLS_REG_RD,
        CLS_BULK_RD
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ECHO,
        ST_STAT,
        ST_HUNT,
        ST_DATA,
        ST_CRC
    } st_e;

    localparam logic [3:0] HDR_NIBBLE = 4'hF;

endpackage

// File: rtl/rsp_op_decode.sv
module rsp_op_decode
    import spi_rsp_pkg::*;
(
    input  logic [7:0] op,
    output cls_e       cls
);
    always_comb begin
        case (op)
            8'hCF, 8'hC5, 8'hC6:         cls = CLS_CTRL;
            8'hC1, 8'hC3, 8'hC7, 8'hC9:  cls = CLS_WRITE;
            8'hCA, 8'hC4:                cls = CLS_REG_RD;
            8'hC2, 8'hC8:                cls = CLS_BULK_RD;
            default:                     cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/rsp_word_pack.sv
module rsp_word_pack #(
    parameter int BYTES = 4,
    localparam int IW   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [IW-1:0]      idx,
    input  logic [7:0]         byte_in,
    output logic [8*BYTES-1:0] word
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (clear)
                lane_q <= '0;
            else if (load && idx == IW'(g))
                lane_q <= byte_in;
        end
        assign word[8*g +: 8] = lane_q;
    end
endmodule

// File: rtl/spi_rsp_check.sv
module spi_rsp_check
    import spi_rsp_pkg::*;
#(
    parameter int HDR_TRIES  = 100,
    parameter int DATA_BYTES = 4,
    parameter int CRC_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [7:0]              opcode,
    input  logic                    crc_en,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    rx_last,
    output logic                    done,
    output logic [1:0]              result,
    output logic                    overrun,
    output logic [8*DATA_BYTES-1:0] rd_word
);
    localparam int CW = $clog2(HDR_TRIES + 1);
    localparam int IW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [CW-1:0] HUNT_LAST = CW'(HDR_TRIES - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_BYTES - 1);
    localparam logic [CW-1:0] CRC_LAST  = CW'(CRC_BYTES - 1);

    typedef struct packed {
        st_e           st;
        cls_e          cls;
        logic [7:0]    op;
        logic          crc;
        logic [CW-1:0] cnt;
        logic          done;
        res_e          res;
        logic          ovr;
    } state_t;

    state_t q, d;
    cls_e   cls_in;
    logic   pack_clr, pack_load;

    rsp_op_decode u_dec (
        .op  (opcode),
        .cls (cls_in)
    );

    rsp_word_pack #(.BYTES(DATA_BYTES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pack_clr),
        .load    (pack_load),
        .idx     (q.cnt[IW-1:0]),
        .byte_in (rx_byte),
        .word    (rd_word)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        pack_clr  = 1'b0;
        pack_load = 1'b0;
        if (start) begin
            d.cls    = cls_in;
            d.op     = opcode;
            d.crc    = crc_en;
            d.cnt    = '0;
            d.ovr    = 1'b0;
            d.res    = RES_OK;
            pack_clr = 1'b1;
            case (cls_in)
                CLS_BAD: begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.res  = RES_FAIL;
                end
                CLS_CTRL: d.st = ST_SKIP;
                default:  d.st = ST_ECHO;
            endcase
        end else if (rx_valid) begin
            case (q.st)
                ST_SKIP: begin
                    if (rx_last) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL; d.ovr = 1'b1;
                    end else begin
                        d.st = ST_ECHO;
                    end
                end
                ST_ECHO: begin
                    if (rx_byte != q.op) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL;
                    end else if (rx_last) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL; d.ovr = 1'b1;
                    end else begin
                        d.st = ST_STAT;
                    end
                end
                ST_STAT: begin
                    if (rx_byte != 8'h00) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL;
                    end else if (q.cls == CLS_CTRL || q.cls == CLS_WRITE) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_OK;
                    end else if (rx_last) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_RESET;
                    end else begin
                        d.st  = ST_HUNT;
                        d.cnt = '0;
                    end
                end
                ST_HUNT: begin
                    if (rx_byte[7:4] == HDR_NIBBLE) begin
                        if (q.cls == CLS_BULK_RD) begin
                            d.st = ST_IDLE; d.done = 1'b1; d.res = RES_OK;
                        end else if (rx_last) begin
                            d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL; d.ovr = 1'b1;
                        end else begin
                            d.st  = ST_DATA;
                            d.cnt = '0;
                        end
                    end else if (q.cnt == HUNT_LAST || rx_last) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_RESET;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_DATA: begin
                    pack_load = 1'b1;
                    if (q.cnt == DATA_LAST) begin
                        if (!q.crc) begin
                            d.st = ST_IDLE; d.done = 1'b1; d.res = RES_OK;
                        end else if (rx_last) begin
                            d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL; d.ovr = 1'b1;
                        end else begin
                            d.st  = ST_CRC;
                            d.cnt = '0;
                        end
                    end else if (rx_last) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL; d.ovr = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_CRC: begin
                    if (q.cnt == CRC_LAST) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_OK;
                    end else if (rx_last) begin
                        d.st = ST_IDLE; d.done = 1'b1; d.res = RES_FAIL; d.ovr = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cls: CLS_BAD, op: 8'h00, crc: 1'b0, cnt: '0,
                   done: 1'b0, res: RES_OK, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign result  = q.res;
    assign overrun = q.ovr;

endmodule

// File: rtl/rsp_check_sva.sv
module rsp_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] opcode,
    input logic       done,
    input logic [1:0] result,
    input logic       overrun
);
    logic [7:0] op_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      op_seen <= 8'h00;
        else if (start)  op_seen <= opcode;
    end

    // R9: unlisted opcode fails at once
    p_unknown_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !(opcode inside {8'hCF, 8'hC5, 8'hC6, 8'hC1, 8'hC3, 8'hC7, 8'hC9,
                                  8'hCA, 8'hC4, 8'hC2, 8'hC8})
        |=> done && result == 2'b01);

    // R8: overrun only with fail
    p_overrun_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && overrun |-> result == 2'b01);

    // R2: result encoding stays within the three codes
    p_encoding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result != 2'b11);

    // R5: reset-required only after a read opcode
    p_reset_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'b10 |-> op_seen inside {8'hCA, 8'hC4, 8'hC2, 8'hC8});

    // R4: write and control commands never ask for reset
    p_write_no_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start && op_seen inside {8'hC1, 8'hC3, 8'hC7, 8'hC9, 8'hCF, 8'hC5, 8'hC6}
        |-> result != 2'b10);

endmodule

bind spi_rsp_check rsp_check_sva u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .done    (done),
    .result  (result),
    .overrun (overrun)
);

// File: tb/sim_spi_rsp_check.sv
`timescale 1ns/1ps
module sim_spi_rsp_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        crc_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_last = 1'b0;
    logic        done;
    logic [1:0]  result;
    logic        overrun;
    logic [31:0] rd_word;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] OK = 2'b00, FL = 2'b01, RS = 2'b10;

    always #10 clk = ~clk;

    spi_rsp_check u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .crc_en(crc_en),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .done(done), .result(result), .overrun(overrun), .rd_word(rd_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic crc);
        start = 1'b1; opcode = op; crc_en = crc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input logic last);
        rx_valid = 1'b1; rx_byte = b; rx_last = last;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic verdict(input string req, input logic [1:0] res, input logic ovr);
        chk({req, " done"}, 32'(done), 32'd1);
        chk({req, " result"}, 32'(result), 32'(res));
        chk({req, " overrun"}, 32'(overrun), 32'(ovr));
    endtask

    task automatic t_reset_idle();
        chk("R10 done", 32'(done), 0);
        chk("R10 result", 32'(result), 0);
        chk("R10 overrun", 32'(overrun), 0);
        chk("R10 word", rd_word, 0);
        put(8'hC9, 1'b0);
        chk("R10 idle byte", 32'(done), 0);
        put(8'h00, 1'b1);
        chk("R10 idle last", 32'(done), 0);
    endtask

    task automatic t_write_ok();
        issue(8'hC9, 1'b0);
        put(8'hC9, 1'b0);
        chk("R4 no early done", 32'(done), 0);
        put(8'h00, 1'b1);
        verdict("R4 write", OK, 1'b0);
    endtask

    task automatic t_control();
        issue(8'hCF, 1'b0);
        put(8'h5A, 1'b0);
        chk("R1 skip no done", 32'(done), 0);
        put(8'hCF, 1'b0);
        put(8'h00, 1'b0);
        verdict("R1 control", OK, 1'b0);
        issue(8'hC5, 1'b0);
        put(8'hC5, 1'b0);
        put(8'h00, 1'b0);
        verdict("R1 echo in skip slot", FL, 1'b0);
    endtask

    task automatic t_echo_status();
        issue(8'hC3, 1'b0);
        put(8'hC1, 1'b0);
        verdict("R2 echo mismatch", FL, 1'b0);
        issue(8'hC1, 1'b0);
        put(8'hC1, 1'b0);
        put(8'h04, 1'b0);
        verdict("R3 status", FL, 1'b0);
    endtask

    task automatic t_reg_read_crc();
        issue(8'hCA, 1'b1);
        put(8'hCA, 1'b0); put(8'h00, 1'b0);
        put(8'h12, 1'b0); put(8'hE0, 1'b0); put(8'h7F, 1'b0);
        put(8'hF3, 1'b0);
        put(8'h11, 1'b0); put(8'h22, 1'b0); put(8'h33, 1'b0); put(8'h44, 1'b0);
        chk("R6 wait crc", 32'(done), 0);
        put(8'hA5, 1'b0);
        chk("R6 wait crc2", 32'(done), 0);
        put(8'h5A, 1'b1);
        verdict("R6 crc read", OK, 1'b0);
        chk("R6 word", rd_word, 32'h44332211);
    endtask

    task automatic t_reg_read_nocrc();
        issue(8'hC4, 1'b0);
        put(8'hC4, 1'b0); put(8'h00, 1'b0); put(8'hF0, 1'b0);
        put(8'hDE, 1'b0); put(8'hAD, 1'b0); put(8'hBE, 1'b0); put(8'hEF, 1'b1);
        verdict("R6 nocrc read", OK, 1'b0);
        chk("R6 word2", rd_word, 32'hEFBEADDE);
    endtask

    task automatic t_hunt_window();
        issue(8'hCA, 1'b0);
        put(8'hCA, 1'b0); put(8'h00, 1'b0);
        for (int i = 0; i < 99; i++) put(8'h00, 1'b0);
        chk("R5 99 fillers", 32'(done), 0);
        put(8'h00, 1'b0);
        verdict("R5 timeout", RS, 1'b0);
        issue(8'hC4, 1'b0);
        put(8'hC4, 1'b0); put(8'h00, 1'b0);
        for (int i = 0; i < 99; i++) put(8'hE5, 1'b0);
        put(8'hF1, 1'b0);
        put(8'h01, 1'b0); put(8'h02, 1'b0); put(8'h03, 1'b0); put(8'h04, 1'b0);
        verdict("R5 header on 100th", OK, 1'b0);
        chk("R5 word", rd_word, 32'h04030201);
        issue(8'hC2, 1'b0);
        put(8'hC2, 1'b0); put(8'h00, 1'b0); put(8'h55, 1'b1);
        verdict("R5 stream end in hunt", RS, 1'b0);
    endtask

    task automatic t_bulk();
        issue(8'hC8, 1'b1);
        put(8'hC8, 1'b0); put(8'h00, 1'b0); put(8'h3C, 1'b0);
        chk("R7 filler", 32'(done), 0);
        put(8'hFF, 1'b0);
        verdict("R7 bulk header", OK, 1'b0);
    endtask

    task automatic t_overrun();
        issue(8'hCA, 1'b0);
        put(8'hCA, 1'b0); put(8'h00, 1'b0); put(8'hF0, 1'b0);
        put(8'h01, 1'b0); put(8'h02, 1'b1);
        verdict("R8 data overrun", FL, 1'b1);
        issue(8'hC9, 1'b0);
        put(8'hC9, 1'b1);
        verdict("R8 echo overrun", FL, 1'b1);
        issue(8'hC4, 1'b1);
        put(8'hC4, 1'b0); put(8'h00, 1'b0); put(8'hF0, 1'b0);
        put(8'h01, 1'b0); put(8'h02, 1'b0); put(8'h03, 1'b0); put(8'h04, 1'b0);
        put(8'h99, 1'b1);
        verdict("R8 crc overrun", FL, 1'b1);
        issue(8'hC1, 1'b0);
        put(8'hC1, 1'b0); put(8'h00, 1'b1);
        verdict("R8 cleared", OK, 1'b0);
    endtask

    task automatic t_unknown();
        issue(8'hAB, 1'b0);
        verdict("R9 unknown", FL, 1'b0);
        @(negedge clk);
        chk("R9 single pulse", 32'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_write_ok();
        t_control();
        t_echo_status();
        t_reg_read_crc();
        t_reg_read_nocrc();
        t_hunt_window();
        t_bulk();
        t_overrun();
        t_unknown();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule